// File: doc/BRIEF.md
# Process data RAM FIFO transfer sequencer

This block moves a run of bytes between a host byte stream and the process data RAM of a fieldbus slave controller. It uses the controller's indirect FIFO window rather than direct addressing. Every access it makes goes through a single 32-bit register port with a request/acknowledge handshake, so it can sit in front of a serial register bridge or any other word-wide access engine.

A transfer is requested with a one-cycle `start`, a direction, a byte address and a byte length. The block first cancels any pending FIFO operation and waits for the controller to go idle. It then programs the address and length, starts the operation and polls until the FIFO reports data or space. After that it streams whole words through the FIFO data register. The first word is aligned to the controller's word grid, so the host's first byte sits in lane `addr[1:0]` of that word. Later words are filled from lane 0. On reads, bytes outside the requested range are dropped. On writes, those bytes are sent as zero.

The host sees `busy` for the length of a transfer. A transfer ends with a one-cycle `done` pulse. A rejected request or a controller that reports an empty FIFO window ends with a one-cycle `err` pulse instead.

Top module: `pdram_fifo_seq`

## Requirements
- R1: A start with address below `PRAM_BASE` (0x1000), with length 0, or with `(addr[1:0] + len)` above `4*MAX_WORDS` raises `err` for one cycle on the cycle after `start`, makes no register access and leaves `busy` low.
- R2: An accepted transfer first writes 0x4000_0000 (cancel, bit 30) to the command register (0x30C for read, 0x314 for write). It then reads that register until bit 31 (busy) reads 0.
- R3: Next it writes the address/length register (0x308 read, 0x310 write) with the byte length in bits [31:16] and the address in bits [15:0].
- R4: Next it writes 0x8000_0000 (bit 31) to the command register and reads that register until bit 0 (available) reads 1.
- R5: If the available read shows a word count (bits [12:8]) of zero, the block raises `err` for one cycle, returns to idle and makes no FIFO data access.
- R6: On a read, FIFO words are read from 0x000. The host receives exactly `len` bytes in address order. The first comes from lane `addr[1:0]` (bits `8k+7:8k` are lane k) of the first word, and later words start at lane 0. Bytes beyond `len` are dropped.
- R7: On a write, FIFO words are written to 0x020 with the same lane placement as R6, and every lane that carries no host byte is zero.
- R8: A transfer makes exactly `ceil((addr[1:0] + len) / 4)` FIFO data accesses.
- R9: Once `reg_req` is raised, it and `reg_we`, `reg_addr` and `reg_wdata` stay unchanged until the cycle after `reg_ack`.
- R10: After reset, `busy`, `done`, `err`, `reg_req`, `rd_valid` and `wr_ready` are low. `busy` is high from the cycle after an accepted start until `done` or `err` pulses, and `done` and `err` never coincide.
- R11: A byte moves only on a cycle with both valid and ready. `rd_valid` and `wr_ready` are never high together. `wr_ready` is raised only during a write transfer, and `rd_byte` holds while `rd_valid` waits for `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request, taken when idle |
| dir_wr | input | 1 | 1 = host to RAM, 0 = RAM to host |
| xfer_addr | input | 16 | Byte address in controller space |
| xfer_len | input | LEN_W | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection or empty-window pulse |
| wr_byte | input | 8 | Host byte to write |
| wr_valid | input | 1 | `wr_byte` is valid |
| wr_ready | output | 1 | Block takes `wr_byte` this cycle |
| rd_byte | output | 8 | Byte read from RAM |
| rd_valid | output | 1 | `rd_byte` is valid |
| rd_ready | input | 1 | Host takes `rd_byte` this cycle |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = register write |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_ack | input | 1 | Access complete, `reg_rdata` valid on reads |
| reg_rdata | input | 32 | Register read data |

## Verification
The assertions check on every cycle the properties that do not depend on data values: the request hold, the access direction of each FIFO data register, the cancel command as the first access after `busy` rises, the quiet rejection, the exclusive end pulses, and the host byte holding steady while it waits. Only the bench's scenarios can show the correct order of the setup accesses and the value written to the address/length register. The same holds for lane placement and zero padding against a controller model with its own byte memory, the FIFO access count, and the empty-window error. These are swept over all four start lanes, a range of short lengths, the longest allowed transfer and each rejection reason.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  // Controller register map for the indirect FIFO window
  localparam logic [15:0] RD_CMD_ADDR  = 16'h030C;
  localparam logic [15:0] RD_AL_ADDR   = 16'h0308;
  localparam logic [15:0] RD_DATA_ADDR = 16'h0000;
  localparam logic [15:0] WR_CMD_ADDR  = 16'h0314;
  localparam logic [15:0] WR_AL_ADDR   = 16'h0310;
  localparam logic [15:0] WR_DATA_ADDR = 16'h0020;

  localparam int BUSY_BIT  = 31;
  localparam int CANCEL_BIT = 30;
  localparam int AVAIL_BIT = 0;
  localparam int CNT_LO    = 8;
  localparam int CNT_HI    = 12;

  localparam logic [31:0] CMD_CANCEL = 32'h1 << CANCEL_BIT;
  localparam logic [31:0] CMD_GO     = 32'h1 << BUSY_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_CANCEL, S_POLL_IDLE, S_PROG, S_GO, S_POLL_AVAIL,
    S_RD_FIFO, S_RD_EMIT, S_WR_LOAD, S_WR_FILL, S_WR_PUT
  } seq_state_e;
endpackage

// File: rtl/pfs_lane.sv
module pfs_lane #(
  parameter int BW = 8,
  parameter int NB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              ld,
  input  logic [NB*BW-1:0]  ld_word,
  input  logic [$clog2(NB)-1:0]   ld_lane,
  input  logic [$clog2(NB+1)-1:0] ld_cnt,
  output logic [NB*BW-1:0]  word,
  output logic              lane_busy,
  output logic [BW-1:0]     rd_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [BW-1:0]     wr_byte,
  input  logic              wr_valid,
  output logic              wr_ready
);
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(NB+1);

  logic [BW-1:0] lanes [NB];
  logic [IW-1:0] idx;
  logic [CW-1:0] left;
  logic          take_wr, take_rd;

  assign take_wr   = wr_mode && wr_valid && (left != '0);
  assign take_rd   = !wr_mode && rd_ready && (left != '0);
  assign lane_busy = (left != '0);
  assign rd_valid  = !wr_mode && (left != '0);
  assign wr_ready  = wr_mode && (left != '0);
  assign rd_byte   = lanes[idx];

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)
          lanes[g] <= '0;
        else if (ld)
          lanes[g] <= ld_word[g*BW +: BW];
        else if (take_wr && (idx == IW'(g)))
          lanes[g] <= wr_byte;
      end
      assign word[g*BW +: BW] = lanes[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      left <= '0;
    end else if (ld) begin
      idx  <= ld_lane;
      left <= ld_cnt;
    end else if (take_wr || take_rd) begin
      idx  <= idx + 1'b1;
      left <= left - 1'b1;
    end
  end

  // R11: a waiting host byte must not change
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_byte));
  // R6/R7: bytes of one word never run past the top lane
  a_r7_lane_bound: assert property (@(posedge clk) disable iff (rst)
    (left != '0) |-> ({1'b0, idx} + (IW+1)'(left) <= (IW+1)'(NB)));
endmodule

// File: rtl/pfs_regport.sv
module pfs_regport
  import pfs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_state_e       nxt,
  input  logic             dir_sel,
  input  logic [15:0]      addr_q,
  input  logic [LEN_W-1:0] len_q,
  input  logic [31:0]      lane_word,
  input  logic             reg_ack,
  output logic             reg_req,
  output logic             reg_we,
  output logic [15:0]      reg_addr,
  output logic [31:0]      reg_wdata
);
  logic        req_n, we_n;
  logic [15:0] addr_n, cmd_a, al_a;
  logic [31:0] wdata_n;

  assign cmd_a = dir_sel ? WR_CMD_ADDR : RD_CMD_ADDR;
  assign al_a  = dir_sel ? WR_AL_ADDR  : RD_AL_ADDR;

  always_comb begin
    req_n = 1'b1; we_n = 1'b0; addr_n = '0; wdata_n = '0;
    unique case (nxt)
      S_CANCEL:     begin we_n = 1'b1; addr_n = cmd_a; wdata_n = CMD_CANCEL; end
      S_POLL_IDLE,
      S_POLL_AVAIL: addr_n = cmd_a;
      S_PROG:       begin we_n = 1'b1; addr_n = al_a;
                          wdata_n = {{(16-LEN_W){1'b0}}, len_q, addr_q}; end
      S_GO:         begin we_n = 1'b1; addr_n = cmd_a; wdata_n = CMD_GO; end
      S_RD_FIFO:    addr_n = RD_DATA_ADDR;
      S_WR_PUT:     begin we_n = 1'b1; addr_n = WR_DATA_ADDR; wdata_n = lane_word; end
      default:      req_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_req <= 1'b0; reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
    end else begin
      reg_req <= req_n; reg_we <= we_n; reg_addr <= addr_n; reg_wdata <= wdata_n;
    end
  end

  // R9: request fields frozen until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));
  // R6: the read data window is only ever read
  a_r6_rd_window: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_addr == RD_DATA_ADDR |-> !reg_we);
  // R7: the write data window is only ever written
  a_r7_wr_window: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_addr == WR_DATA_ADDR |-> reg_we);
endmodule

// File: rtl/pdram_fifo_seq.sv
module pdram_fifo_seq
  import pfs_pkg::*;
#(
  parameter int          LEN_W     = 8,
  parameter int          MAX_WORDS = 31,
  parameter logic [15:0] PRAM_BASE = 16'h1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_wr,
  input  logic [15:0]      xfer_addr,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic [7:0]       wr_byte,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             reg_req,
  output logic             reg_we,
  output logic [15:0]      reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [31:0]      reg_rdata
);
  localparam int NB = 4;
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(NB+1);
  localparam int NW = LEN_W + 2;
  localparam logic [NW-1:0] MAX_BYTES = NW'(NB * MAX_WORDS);

  seq_state_e       state, nxt;
  logic             dir_q, first_q;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic             err_n, done_n, lane_ld, lane_busy, bad_req, dir_sel;
  logic [NW-1:0]    need_bytes;
  logic [IW-1:0]    lane_sel;
  logic [CW-1:0]    room, cnt;
  logic [31:0]      lane_word;

  assign need_bytes = NW'(xfer_len) + NW'(xfer_addr[IW-1:0]);
  assign bad_req    = (xfer_addr < PRAM_BASE) || (xfer_len == '0) || (need_bytes > MAX_BYTES);
  assign dir_sel    = (state == S_IDLE) ? dir_wr : dir_q;

  assign lane_sel = first_q ? addr_q[IW-1:0] : '0;
  assign room     = CW'(NB) - CW'(lane_sel);
  assign cnt      = (rem_q < LEN_W'(room)) ? CW'(rem_q) : room;

  always_comb begin
    nxt = state; err_n = 1'b0; done_n = 1'b0; lane_ld = 1'b0;
    unique case (state)
      S_IDLE:       if (start) begin
                      if (bad_req) err_n = 1'b1;
                      else         nxt = S_CANCEL;
                    end
      S_CANCEL:     if (reg_ack) nxt = S_POLL_IDLE;
      S_POLL_IDLE:  if (reg_ack && !reg_rdata[BUSY_BIT]) nxt = S_PROG;
      S_PROG:       if (reg_ack) nxt = S_GO;
      S_GO:         if (reg_ack) nxt = S_POLL_AVAIL;
      S_POLL_AVAIL: if (reg_ack && reg_rdata[AVAIL_BIT]) begin
                      if (reg_rdata[CNT_HI:CNT_LO] == '0) begin
                        err_n = 1'b1; nxt = S_IDLE;
                      end else begin
                        nxt = dir_q ? S_WR_LOAD : S_RD_FIFO;
                      end
                    end
      S_RD_FIFO:    if (reg_ack) begin lane_ld = 1'b1; nxt = S_RD_EMIT; end
      S_RD_EMIT:    if (!lane_busy) begin
                      if (rem_q == '0) begin done_n = 1'b1; nxt = S_IDLE; end
                      else nxt = S_RD_FIFO;
                    end
      S_WR_LOAD:    begin lane_ld = 1'b1; nxt = S_WR_FILL; end
      S_WR_FILL:    if (!lane_busy) nxt = S_WR_PUT;
      S_WR_PUT:     if (reg_ack) begin
                      if (rem_q == '0) begin done_n = 1'b1; nxt = S_IDLE; end
                      else nxt = S_WR_LOAD;
                    end
      default:      nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      dir_q <= 1'b0; first_q <= 1'b0; addr_q <= '0; len_q <= '0; rem_q <= '0;
    end else begin
      state <= nxt;
      busy  <= (nxt != S_IDLE);
      done  <= done_n;
      err   <= err_n;
      if (state == S_IDLE && start) begin
        dir_q <= dir_wr; addr_q <= xfer_addr; len_q <= xfer_len;
        rem_q <= xfer_len; first_q <= 1'b1;
      end else if (lane_ld) begin
        rem_q   <= rem_q - LEN_W'(cnt);
        first_q <= 1'b0;
      end
    end
  end

  pfs_lane #(.BW(8), .NB(NB)) u_lane (
    .clk(clk), .rst(rst), .wr_mode(dir_q), .ld(lane_ld),
    .ld_word(dir_q ? 32'h0 : reg_rdata), .ld_lane(lane_sel), .ld_cnt(cnt),
    .word(lane_word), .lane_busy(lane_busy),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_byte(wr_byte), .wr_valid(wr_valid), .wr_ready(wr_ready)
  );

  pfs_regport #(.LEN_W(LEN_W)) u_regport (
    .clk(clk), .rst(rst), .nxt(nxt), .dir_sel(dir_sel), .addr_q(addr_q),
    .len_q(len_q), .lane_word(lane_word), .reg_ack(reg_ack),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  // R2: the first access of every accepted transfer is the cancel command
  a_r2_cancel_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> reg_req && reg_we && reg_wdata == CMD_CANCEL &&
                    (reg_addr == RD_CMD_ADDR || reg_addr == WR_CMD_ADDR));
  // R1: a rejection never starts a transfer
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    err && !$past(busy) |-> !busy && !reg_req);
  // R10: completion and error are exclusive, and both leave the block idle
  a_r10_end_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11: only one byte stream is live at a time
  a_r11_one_stream: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_ready));
endmodule

// File: tb/test_pdram_fifo_seq.sv
module test_pdram_fifo_seq;
  localparam int LEN_W = 8;
  localparam int MAX_WORDS = 31;

  logic clk = 1'b0;
  logic rst, start, dir_wr, busy, done, err;
  logic [15:0] xfer_addr;
  logic [LEN_W-1:0] xfer_len;
  logic [7:0] wr_byte, rd_byte;
  logic wr_valid, wr_ready, rd_valid, rd_ready;
  logic reg_req, reg_we, reg_ack;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  pdram_fifo_seq #(.LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)) i_pdram_fifo_seq (
    .clk(clk), .rst(rst), .start(start), .dir_wr(dir_wr), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .busy(busy), .done(done), .err(err),
    .wr_byte(wr_byte), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata));

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [7:0] mem [256];
  logic [7:0] src [128];
  logic [7:0] got [128];
  int cur_off = 0, cur_len = 0, xfer_id = 0;
  bit cur_wr = 0, force_zero = 0;

  // controller model state
  int phase = 0, idle_polls = 0, av_polls = 0, waddr = 0;
  int seq_err = 0, pad_err = 0, fifo_acc = 0, tot_acc = 0, hold_err = 0;
  bit held = 0;
  logic [15:0] s_addr; logic s_we; logic [31:0] s_wdata;

  always @(negedge clk) begin
    if (rst) begin
      reg_ack = 0; reg_rdata = 0; held = 0; phase = 0;
    end else if (reg_ack) begin
      reg_ack = 0;
    end else if (reg_req) begin
      if (!held) begin
        held = 1; s_addr = reg_addr; s_we = reg_we; s_wdata = reg_wdata;
      end else begin
        held = 0;
        if (s_addr != reg_addr || s_we != reg_we || s_wdata != reg_wdata) hold_err++;
        tot_acc++;
        reg_rdata = 0;
        if (reg_addr == (cur_wr ? 16'h0314 : 16'h030C)) begin
          if (reg_we) begin
            if (reg_wdata == 32'h4000_0000) begin
              phase = 1; idle_polls = 2; waddr = cur_off & ~3; fifo_acc = 0;
            end else if (reg_wdata == 32'h8000_0000) begin
              if (phase != 3) seq_err++;
              phase = 4; av_polls = 2;
            end else seq_err++;
          end else if (phase == 1) begin
            if (idle_polls > 0) begin reg_rdata = 32'h8000_0000; idle_polls--; end
            else phase = 2;
          end else if (phase == 4) begin
            if (av_polls > 0) av_polls--;
            else begin
              reg_rdata = 32'h1 | ((force_zero ? 0 : ((cur_off % 4) + cur_len + 3) / 4) << 8);
              phase = 5;
            end
          end
        end else if (reg_we && reg_addr == (cur_wr ? 16'h0310 : 16'h0308)) begin
          if (phase != 2) seq_err++;
          if (reg_wdata != {16'(cur_len), 16'(16'h1000 + cur_off)}) seq_err++;
          phase = 3;
        end else if (!cur_wr && !reg_we && reg_addr == 16'h0000) begin
          if (phase != 5) seq_err++;
          for (int k = 0; k < 4; k++) reg_rdata[k*8 +: 8] = mem[(waddr + k) & 255];
          waddr += 4; fifo_acc++;
        end else if (cur_wr && reg_we && reg_addr == 16'h0020) begin
          if (phase != 5) seq_err++;
          for (int k = 0; k < 4; k++) begin
            int a;
            a = waddr + k;
            if (a >= cur_off && a < cur_off + cur_len) mem[a & 255] = reg_wdata[k*8 +: 8];
            else if (reg_wdata[k*8 +: 8] != 8'h00) pad_err++;
          end
          waddr += 4; fifo_acc++;
        end else seq_err++;
        reg_ack = 1;
      end
    end
  end

  // host stream model
  int tick = 0, wr_idx = 0, rd_cnt = 0, seen_id = 0, stream_err = 0;
  bit vs_w = 0, rs_w = 0, rv_s = 0, rr_s = 0;
  logic [7:0] rb_s;
  always @(negedge clk) begin
    tick++;
    if (xfer_id != seen_id) begin
      seen_id = xfer_id; wr_idx = 0; rd_cnt = 0; vs_w = 0; rv_s = 0;
    end
    if (vs_w && rs_w) wr_idx++;
    wr_valid = cur_wr && (wr_idx < cur_len) && (tick % 4 != 2);
    wr_byte  = wr_valid ? src[wr_idx] : 8'h00;
    vs_w = wr_valid; rs_w = wr_ready;
    if (rv_s && rr_s) begin
      if (rd_cnt < 128) got[rd_cnt] = rb_s;
      rd_cnt++;
    end
    rd_ready = (tick % 3 != 1);
    rv_s = rd_valid; rr_s = rd_ready; rb_s = rd_byte;
    if (!rst && rd_valid && wr_ready) stream_err++;
    if (!rst && !cur_wr && wr_ready) stream_err++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(bit wr, int off, int len, bit fz, bit bad_addr);
    int seq0, pad0, hold0, str0, tot0, words, waited, mism;
    bit saw_done, saw_err, busy1;
    logic [7:0] expm [256];
    cur_wr = wr; cur_off = off; cur_len = len; force_zero = fz;
    words = ((off % 4) + len + 3) / 4;
    for (int i = 0; i < 128; i++) src[i] = 8'((off * 7 + i * 13 + len * 3 + 1) & 255);
    for (int i = 0; i < 256; i++) expm[i] = mem[i];
    if (wr) for (int i = 0; i < len; i++) expm[(off + i) & 255] = src[i];
    xfer_id++;
    @(negedge clk);
    seq0 = seq_err; pad0 = pad_err; hold0 = hold_err; str0 = stream_err; tot0 = tot_acc;
    start = 1; dir_wr = wr; xfer_len = LEN_W'(len);
    xfer_addr = bad_addr ? 16'h0FFF : 16'(16'h1000 + off);
    @(negedge clk);
    start = 0;
    busy1 = busy;
    saw_done = 0; saw_err = 0; waited = 0;
    while (!done && !err && waited < 3000) begin @(negedge clk); waited++; end
    saw_done = done; saw_err = err;
    chk(!(done && err), "R10", "done and err together", done, 0);
    @(negedge clk); @(negedge clk);
    chk(!busy, "R10", "busy after end", busy, 0);
    chk(hold_err == hold0, "R9", "request changed before ack", hold_err - hold0, 0);
    chk(stream_err == str0, "R11", "stream handshake violations", stream_err - str0, 0);
    if (bad_addr || len == 0 || (off % 4) + len > 4 * MAX_WORDS) begin
      chk(saw_err && waited == 0, "R1", "rejection err pulse", saw_err, 1);
      chk(!busy1, "R1", "busy after rejected start", busy1, 0);
      chk(tot_acc == tot0, "R1", "accesses after rejection", tot_acc - tot0, 0);
    end else if (fz) begin
      chk(saw_err, "R5", "err on empty window", saw_err, 1);
      chk(fifo_acc == 0, "R5", "FIFO accesses on empty window", fifo_acc, 0);
      chk(seq_err == seq0, "R2 R3 R4", "setup sequence faults", seq_err - seq0, 0);
    end else begin
      chk(busy1, "R10", "busy after accepted start", busy1, 1);
      chk(saw_done && !saw_err, "R10", "done pulse", saw_done, 1);
      chk(seq_err == seq0, "R2 R3 R4", "setup sequence faults", seq_err - seq0, 0);
      chk(fifo_acc == words, "R8", "FIFO data accesses", fifo_acc, words);
      if (wr) begin
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != expm[i]) mism++;
        chk(mism == 0, "R7", "RAM bytes wrong after write", mism, 0);
        chk(pad_err == pad0, "R7", "nonzero pad lanes", pad_err - pad0, 0);
        chk(rd_cnt == 0, "R11", "read bytes during write", rd_cnt, 0);
      end else begin
        chk(rd_cnt == len, "R6", "bytes delivered", rd_cnt, len);
        for (int i = 0; i < len && i < 128; i++)
          chk(got[i] == mem[(off + i) & 255], "R6", $sformatf("byte %0d", i),
              int'(got[i]), int'(mem[(off + i) & 255]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 29 + 5) & 255);
    rst = 1; start = 0; dir_wr = 0; xfer_addr = 0; xfer_len = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !err, "R10", "status after reset", {busy, done, err}, 0);
    chk(!reg_req, "R9", "reg_req after reset", reg_req, 0);
    chk(!rd_valid && !wr_ready, "R11", "streams after reset", {rd_valid, wr_ready}, 0);
    // sweep all start lanes and short lengths, both directions
    for (int d = 0; d < 2; d++)
      for (int lane = 0; lane < 4; lane++)
        for (int len = 1; len <= 10; len++)
          run(d[0], 32 + 16 * lane + lane, len, 0, 0);
    // longest allowed transfer, both directions
    run(0, 3, 4 * MAX_WORDS - 3, 0, 0);
    run(1, 3, 4 * MAX_WORDS - 3, 0, 0);
    run(0, 0, 4 * MAX_WORDS, 0, 0);
    // rejections: R1
    run(0, 3, 4 * MAX_WORDS - 2, 0, 0);
    run(1, 8, 0, 0, 0);
    run(0, 8, 4, 0, 1);
    run(1, 8, 4, 0, 1);
    // empty window: R5
    run(0, 5, 6, 1, 0);
    run(1, 2, 9, 1, 0);
    // recovery after an error
    run(0, 1, 7, 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule